// File: doc/BRIEF.md
# Multi-Level Translation Lookaside Cache

This block is a small fully associative cache of address translations for an I/O memory management unit. Each stored translation is tagged with an address-space identifier, the input address aligned to the translation's block size, a granule code and the table level the translation came from. A lookup names an address-space identifier, an input address, a granule code and the translation table size field. From these it derives the first table level to probe. It then returns the matching translation of the lowest level, from the starting level down to level 3.

Software-side agents, or a page-table walker, write translations with an insert request. They remove them with one of three invalidation kinds: everything, one address-space identifier, or an address range. The range kind has a fast path that removes one exactly tagged entry. The block counts lookup hits and misses. Each of the three request channels uses a valid/ready handshake. Only one request is accepted per cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, both counters read zero, `rspValid` is low, and any lookup misses.
- R2: A lookup accepted at a clock edge gives `rspValid` high for one cycle after that edge. It hits when one valid entry has the same identifier and the same granule code, has a level not below the start level, and satisfies (lookup address AND NOT entry mask) equal to the entry address. With g = log2 of the granule size, the granule code is 1 for g=12, 2 for g=14 and 3 for g=16. The start level is 4 − (60 − tsz)/(g − 3), using integer division, clamped at 0. A quotient of 0 or less gives start level 4, which probes nothing. When several entries match, the lowest level is returned, together with its level, its permission, and its output address ORed with (lookup address AND mask).
- R3: An entry's mask has its lowest s bits set, with s = g + (3 − level)·(g − 3), capped at the address width. An insert stores the input address and the output address with those bits cleared.
- R4: An insert into a cache that is not full overwrites an existing entry with the same four tag fields. Otherwise it takes a free slot. So repeated inserts of one tag consume a single slot.
- R5: An insert that arrives while every slot is valid first invalidates all entries, then writes the new one. Afterwards exactly that entry is valid.
- R6: An invalidation of kind 0 removes every entry.
- R7: An invalidation of kind 1 removes every entry whose identifier equals `invAsid` and leaves the others.
- R8: An invalidation of kind 2 scans the entries. It removes an entry when its identifier matches (or `invAnyAsid` is high), and either (invAddr AND NOT entry mask) equals the entry address, or (entry address AND NOT rangeMask) equals invAddr. Here rangeMask = (invPages << gr) − 1, where gr = 12 for granule code 0 and otherwise 2·code + 10.
- R9: For kind 2 with a nonzero `invLevel`, `invPages` equal to 1 and `invAnyAsid` low, an entry whose four tag fields equal (invAsid, invAddr, invTg, invLevel) is removed alone, and the scan is skipped. When no such entry exists the scan of R8 applies.
- R10: Every accepted lookup increments `hitCount` on a hit or `missCount` on a miss, at the edge that accepts it.
- R11: Invalidation takes precedence over insert, and insert over lookup. A request is held off (its ready low) while a higher-priority valid is present. A held lookup sees the state left by the winning operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request valid |
| lkReady | output | 1 | Lookup accepted this cycle |
| lkAsid | input | ASID_W | Lookup address-space identifier |
| lkAddr | input | ADDR_W | Lookup input address |
| lkTg | input | 2 | Lookup granule code |
| lkTsz | input | 6 | Lookup table size field |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspOutAddr | output | ADDR_W | Translated address |
| rspLevel | output | 2 | Level of the hit entry |
| rspPerm | output | 2 | Permission of the hit entry |
| insValid | input | 1 | Insert request valid |
| insReady | output | 1 | Insert accepted this cycle |
| insAsid | input | ASID_W | Insert identifier |
| insAddr | input | ADDR_W | Insert input address |
| insTg | input | 2 | Insert granule code |
| insLevel | input | 2 | Insert table level |
| insOutAddr | input | ADDR_W | Insert output address |
| insPerm | input | 2 | Insert permission |
| invValid | input | 1 | Invalidation request valid |
| invReady | output | 1 | Invalidation accepted this cycle |
| invKind | input | 2 | 0 all, 1 by identifier, 2 range, 3 none |
| invAnyAsid | input | 1 | Range invalidation ignores the identifier |
| invAsid | input | ASID_W | Invalidation identifier |
| invAddr | input | ADDR_W | Range base address |
| invTg | input | 2 | Range granule code |
| invPages | input | PAGE_W | Range page count |
| invLevel | input | 2 | Range level hint, 0 for none |
| hitCount | output | CNT_W | Lookup hit counter |
| missCount | output | CNT_W | Lookup miss counter |

## Verification
The functions that meet in one cycle are a lookup and an invalidation, and likewise a lookup and an insert. The bench raises both valids on the same clock low phase. It checks that the lookup ready is low while the insert or invalidation ready is high. It keeps the lookup pending and then judges its late result against the contents left by the winner: a miss after a full flush, and a hit on the entry the insert just wrote. Random phases interleave the three channels against a bench model. The directed cases cover the exact-tag fast path, which spares an overlapping larger block, and the fallback scan, which does not.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  typedef struct packed {
    logic doLookup;
    logic doInsert;
    logic doFlushAll;
    logic doFlushAsid;
    logic doRange;
  } cacheStrobe_t;

  typedef enum logic [1:0] {
    INV_ALL   = 2'd0,
    INV_ASID  = 2'd1,
    INV_RANGE = 2'd2,
    INV_NONE  = 2'd3
  } invKind_e;

  // log2 of the granule size; code 0 stands for 4 KB
  function automatic int granLog(logic [1:0] tg);
    return (tg == 2'd0) ? 12 : (int'(tg) * 2 + 10);
  endfunction

  // first level probed by a lookup, 4 means none
  function automatic logic [2:0] startLevel(logic [1:0] tg, logic [5:0] tsz);
    int g;
    int q;
    g = granLog(tg);
    q = (60 - int'(tsz)) / (g - 3);
    if (q >= 4) return 3'd0;
    if (q <= 0) return 3'd4;
    return 3'(4 - q);
  endfunction

endpackage

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
  import xlat_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lkValid,
  input  logic         insValid,
  input  logic         invValid,
  input  logic [1:0]   invKind,
  output logic         lkReady,
  output logic         insReady,
  output logic         invReady,
  output cacheStrobe_t strobe
);

  // fixed priority: invalidate, then insert, then lookup
  assign invReady = 1'b1;
  assign insReady = !invValid;
  assign lkReady  = !invValid && !insValid;

  always_comb begin
    strobe             = '0;
    strobe.doFlushAll  = invValid && (invKind == INV_ALL);
    strobe.doFlushAsid = invValid && (invKind == INV_ASID);
    strobe.doRange     = invValid && (invKind == INV_RANGE);
    strobe.doInsert    = insValid && insReady;
    strobe.doLookup    = lkValid && lkReady;
  end

  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("more than one operation strobed"); // R11

  AST_LOOKUP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && (invValid || insValid)) |-> !strobe.doLookup)
    else $error("lookup strobed beside a higher priority request"); // R11

endmodule

// File: rtl/xlat_cache_dp.sv
module xlat_cache_dp
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48,
  parameter int ASID_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  cacheStrobe_t       strobe,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [ADDR_W-1:0]  lkAddr,
  input  logic [1:0]         lkTg,
  input  logic [5:0]         lkTsz,
  output logic               rspValid,
  output logic               rspHit,
  output logic [ADDR_W-1:0]  rspOutAddr,
  output logic [1:0]         rspLevel,
  output logic [1:0]         rspPerm,
  input  logic [ASID_W-1:0]  insAsid,
  input  logic [ADDR_W-1:0]  insAddr,
  input  logic [1:0]         insTg,
  input  logic [1:0]         insLevel,
  input  logic [ADDR_W-1:0]  insOutAddr,
  input  logic [1:0]         insPerm,
  input  logic               invAnyAsid,
  input  logic [ASID_W-1:0]  invAsid,
  input  logic [ADDR_W-1:0]  invAddr,
  input  logic [1:0]         invTg,
  input  logic [PAGE_W-1:0]  invPages,
  input  logic [1:0]         invLevel,
  output logic [CNT_W-1:0]   hitCount,
  output logic [CNT_W-1:0]   missCount
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic              vld;
    logic [ASID_W-1:0] asid;
    logic [1:0]        tg;
    logic [1:0]        lvl;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] outAddr;
    logic [1:0]        perm;
  } entry_t;

  // low bits covered by one block of the given granule and level
  function automatic logic [ADDR_W-1:0] levelMask(logic [1:0] tg, logic [1:0] lvl);
    int g;
    int sh;
    logic [ADDR_W-1:0] m;
    g  = granLog(tg);
    sh = g + (3 - int'(lvl)) * (g - 3);
    for (int b = 0; b < ADDR_W; b++) m[b] = (b < sh);
    return m;
  endfunction

  entry_t ent [ENTRIES];

  logic [ENTRIES-1:0] vldVec, hitVec, insMatch, exactVec, scanVec, killVec;
  logic [2:0]         lkStart;
  logic [ADDR_W-1:0]  insMask, insBase, rangeMask;
  logic               cacheFull, useExact;
  logic               selFound, matchFound;
  logic [1:0]         selLvl;
  logic [IDX_W-1:0]   selIdx, matchIdx, freeIdx, writeIdx;
  entry_t             newEnt;

  assign lkStart   = startLevel(lkTg, lkTsz);
  assign insMask   = levelMask(insTg, insLevel);
  assign insBase   = insAddr & ~insMask;
  assign rangeMask = ({{(ADDR_W-PAGE_W){1'b0}}, invPages} << granLog(invTg)) - ADDR_W'(1);
  assign cacheFull = &vldVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
    assign vldVec[i]   = ent[i].vld;
    assign hitVec[i]   = ent[i].vld && (ent[i].asid == lkAsid) && (ent[i].tg == lkTg) &&
                         ({1'b0, ent[i].lvl} >= lkStart) &&
                         ((lkAddr & ~ent[i].mask) == ent[i].addr);
    assign insMatch[i] = ent[i].vld && (ent[i].asid == insAsid) && (ent[i].tg == insTg) &&
                         (ent[i].lvl == insLevel) && (ent[i].addr == insBase);
    assign exactVec[i] = ent[i].vld && (ent[i].asid == invAsid) && (ent[i].tg == invTg) &&
                         (ent[i].lvl == invLevel) && (ent[i].addr == invAddr);
    assign scanVec[i]  = ent[i].vld && (invAnyAsid || (ent[i].asid == invAsid)) &&
                         (((invAddr & ~ent[i].mask) == ent[i].addr) ||
                          ((ent[i].addr & ~rangeMask) == invAddr));

    AST_ASID_REMOVED: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.doFlushAsid && ent[i].vld && (ent[i].asid == invAsid)) |=> !ent[i].vld)
      else $error("entry of flushed identifier survived"); // R7
  end

  assign useExact = (invLevel != 2'd0) && (invPages == PAGE_W'(1)) && !invAnyAsid && (|exactVec);
  assign killVec  = useExact ? exactVec : scanVec;

  // lowest-level hit wins, as the probe runs from the start level downward
  always_comb begin
    selFound = 1'b0;
    selLvl   = 2'd3;
    selIdx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i] && (!selFound || (ent[i].lvl < selLvl))) begin
        selFound = 1'b1;
        selLvl   = ent[i].lvl;
        selIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    matchFound = 1'b0;
    matchIdx   = '0;
    freeIdx    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (insMatch[i]) begin
        matchFound = 1'b1;
        matchIdx   = IDX_W'(i);
      end
      if (!vldVec[i]) freeIdx = IDX_W'(i);
    end
    writeIdx = matchFound ? matchIdx : freeIdx;
  end

  always_comb begin
    newEnt.vld     = 1'b1;
    newEnt.asid    = insAsid;
    newEnt.tg      = insTg;
    newEnt.lvl     = insLevel;
    newEnt.addr    = insBase;
    newEnt.mask    = insMask;
    newEnt.outAddr = insOutAddr & ~insMask;
    newEnt.perm    = insPerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (strobe.doInsert) begin
      if (cacheFull) begin
        for (int i = 0; i < ENTRIES; i++) ent[i].vld <= 1'b0;
        ent[0] <= newEnt;
      end else begin
        ent[writeIdx] <= newEnt;
      end
    end else if (strobe.doFlushAll) begin
      for (int i = 0; i < ENTRIES; i++) ent[i].vld <= 1'b0;
    end else if (strobe.doFlushAsid) begin
      for (int i = 0; i < ENTRIES; i++)
        if (ent[i].vld && (ent[i].asid == invAsid)) ent[i].vld <= 1'b0;
    end else if (strobe.doRange) begin
      for (int i = 0; i < ENTRIES; i++)
        if (killVec[i]) ent[i].vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspOutAddr <= '0;
      rspLevel   <= '0;
      rspPerm    <= '0;
      hitCount   <= '0;
      missCount  <= '0;
    end else begin
      rspValid <= strobe.doLookup;
      if (strobe.doLookup) begin
        rspHit     <= selFound;
        rspLevel   <= selFound ? ent[selIdx].lvl : 2'd0;
        rspPerm    <= selFound ? ent[selIdx].perm : 2'd0;
        rspOutAddr <= selFound ? (ent[selIdx].outAddr | (lkAddr & ent[selIdx].mask)) : '0;
        if (selFound) hitCount  <= hitCount + CNT_W'(1);
        else          missCount <= missCount + CNT_W'(1);
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFlushAll |=> (vldVec == '0)) else $error("entries left after full flush"); // R6

  AST_FULL_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doInsert && cacheFull) |=> ($countones(vldVec) == 1))
    else $error("insert into full cache left more than one entry"); // R5

  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doLookup && selFound) |=> (rspHit && (hitCount == $past(hitCount) + CNT_W'(1))))
    else $error("hit counter out of step"); // R10

  AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doLookup && !selFound) |=> (!rspHit && (missCount == $past(missCount) + CNT_W'(1))))
    else $error("miss counter out of step"); // R10

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48,
  parameter int ASID_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [1:0]        lkTg,
  input  logic [5:0]        lkTsz,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspOutAddr,
  output logic [1:0]        rspLevel,
  output logic [1:0]        rspPerm,
  input  logic              insValid,
  output logic              insReady,
  input  logic [ASID_W-1:0] insAsid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [1:0]        insTg,
  input  logic [1:0]        insLevel,
  input  logic [ADDR_W-1:0] insOutAddr,
  input  logic [1:0]        insPerm,
  input  logic              invValid,
  output logic              invReady,
  input  logic [1:0]        invKind,
  input  logic              invAnyAsid,
  input  logic [ASID_W-1:0] invAsid,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic [1:0]        invTg,
  input  logic [PAGE_W-1:0] invPages,
  input  logic [1:0]        invLevel,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  cacheStrobe_t strobe;

  xlat_cache_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .lkValid  (lkValid),
    .insValid (insValid),
    .invValid (invValid),
    .invKind  (invKind),
    .lkReady  (lkReady),
    .insReady (insReady),
    .invReady (invReady),
    .strobe   (strobe)
  );

  xlat_cache_dp #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .ASID_W  (ASID_W),
    .PAGE_W  (PAGE_W),
    .CNT_W   (CNT_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lkAsid     (lkAsid),
    .lkAddr     (lkAddr),
    .lkTg       (lkTg),
    .lkTsz      (lkTsz),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspOutAddr (rspOutAddr),
    .rspLevel   (rspLevel),
    .rspPerm    (rspPerm),
    .insAsid    (insAsid),
    .insAddr    (insAddr),
    .insTg      (insTg),
    .insLevel   (insLevel),
    .insOutAddr (insOutAddr),
    .insPerm    (insPerm),
    .invAnyAsid (invAnyAsid),
    .invAsid    (invAsid),
    .invAddr    (invAddr),
    .invTg      (invTg),
    .invPages   (invPages),
    .invLevel   (invLevel),
    .hitCount   (hitCount),
    .missCount  (missCount)
  );

endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;

  localparam int N  = 8;
  localparam int AW = 48;
  localparam int PW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lkValid = 0, lkReady;
  logic [15:0]   lkAsid = 0;
  logic [AW-1:0] lkAddr = 0;
  logic [1:0]    lkTg = 0;
  logic [5:0]    lkTsz = 0;
  logic          rspValid, rspHit;
  logic [AW-1:0] rspOutAddr;
  logic [1:0]    rspLevel, rspPerm;
  logic          insValid = 0, insReady;
  logic [15:0]   insAsid = 0;
  logic [AW-1:0] insAddr = 0, insOutAddr = 0;
  logic [1:0]    insTg = 0, insLevel = 0, insPerm = 0;
  logic          invValid = 0, invReady;
  logic [1:0]    invKind = 0;
  logic          invAnyAsid = 0;
  logic [15:0]   invAsid = 0;
  logic [AW-1:0] invAddr = 0;
  logic [1:0]    invTg = 0, invLevel = 0;
  logic [PW-1:0] invPages = 0;
  logic [CW-1:0] hitCount, missCount;

  xlat_cache dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0, expHits = 0, expMisses = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // bench model of the cache contents
  bit            mV[N];
  logic [15:0]   mAs[N];
  logic [1:0]    mTg[N], mLv[N], mPm[N];
  logic [AW-1:0] mAd[N], mMk[N], mOut[N];

  function automatic int gLog(int tg);
    return (tg == 0) ? 12 : tg * 2 + 10;
  endfunction

  function automatic logic [AW-1:0] bMask(int tg, int lvl);
    int g = gLog(tg);
    int sh = g + (3 - lvl) * (g - 3);
    logic [AW-1:0] m = '0;
    for (int b = 0; b < AW && b < sh; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic int bStart(int tg, int tsz);
    int q = (64 - tsz - 4) / (gLog(tg) - 3);
    if (q >= 4) return 0;
    if (q <= 0) return 4;
    return 4 - q;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelInsert(logic [15:0] a, logic [AW-1:0] ad, int tg, int lv, logic [AW-1:0] o, int pm);
    int cnt = 0, slot = -1;
    logic [AW-1:0] mk = bMask(tg, lv);
    for (int i = 0; i < N; i++) if (mV[i]) cnt++;
    if (cnt == N) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
      slot = 0;
    end else begin
      for (int i = 0; i < N; i++)
        if (mV[i] && mAs[i] == a && mTg[i] == 2'(tg) && mLv[i] == 2'(lv) && mAd[i] == (ad & ~mk)) slot = i;
      for (int i = 0; i < N; i++) if (!mV[i] && slot < 0) slot = i;
    end
    mV[slot] = 1; mAs[slot] = a; mTg[slot] = 2'(tg); mLv[slot] = 2'(lv);
    mAd[slot] = ad & ~mk; mMk[slot] = mk; mOut[slot] = o & ~mk; mPm[slot] = 2'(pm);
  endtask

  task automatic modelInval(int kind, bit any, logic [15:0] a, logic [AW-1:0] ad, int tg, int pages, int lv);
    bit exact = 0;
    logic [AW-1:0] rm = AW'((64'(pages) << gLog(tg)) - 64'd1);
    if (kind == 0) for (int i = 0; i < N; i++) mV[i] = 0;
    else if (kind == 1) begin
      for (int i = 0; i < N; i++) if (mAs[i] == a) mV[i] = 0;
    end else if (kind == 2) begin
      if (lv != 0 && pages == 1 && !any)
        for (int i = 0; i < N; i++)
          if (mV[i] && mAs[i] == a && mTg[i] == 2'(tg) && mLv[i] == 2'(lv) && mAd[i] == ad) begin
            mV[i] = 0; exact = 1;
          end
      if (!exact)
        for (int i = 0; i < N; i++)
          if (mV[i] && (any || mAs[i] == a) &&
              (((ad & ~mMk[i]) == mAd[i]) || ((mAd[i] & ~rm) == ad))) mV[i] = 0;
    end
  endtask

  task automatic doInsert(logic [15:0] a, logic [AW-1:0] ad, int tg, int lv, logic [AW-1:0] o, int pm);
    insAsid = a; insAddr = ad; insTg = 2'(tg); insLevel = 2'(lv); insOutAddr = o; insPerm = 2'(pm);
    insValid = 1;
    @(posedge clk); @(negedge clk);
    insValid = 0;
    modelInsert(a, ad, tg, lv, o, pm);
  endtask

  task automatic doInval(int kind, bit any, logic [15:0] a, logic [AW-1:0] ad, int tg, int pages, int lv);
    invKind = 2'(kind); invAnyAsid = any; invAsid = a; invAddr = ad; invTg = 2'(tg);
    invPages = PW'(pages); invLevel = 2'(lv);
    invValid = 1;
    @(posedge clk); @(negedge clk);
    invValid = 0;
    modelInval(kind, any, a, ad, tg, pages, lv);
  endtask

  task automatic lkSet(logic [15:0] a, logic [AW-1:0] ad, int tg, int tsz);
    lkAsid = a; lkAddr = ad; lkTg = 2'(tg); lkTsz = 6'(tsz); lkValid = 1;
  endtask

  // waits for acceptance edge, then checks the result against the model
  task automatic lkFinish(string req);
    int best = -1, st;
    @(posedge clk); @(negedge clk);
    lkValid = 0;
    st = bStart(lkTg, lkTsz);
    for (int i = 0; i < N; i++)
      if (mV[i] && mAs[i] == lkAsid && mTg[i] == lkTg && int'(mLv[i]) >= st &&
          ((lkAddr & ~mMk[i]) == mAd[i]))
        if (best < 0 || mLv[i] < mLv[best]) best = i;
    chk({req, " rspValid"}, rspValid, 1);
    chk({req, " hit"}, rspHit, best >= 0);
    if (best >= 0) begin
      expHits++;
      chk({req, " level"}, rspLevel, mLv[best]);
      chk({req, " outAddr"}, rspOutAddr, mOut[best] | (lkAddr & mMk[best]));
      chk({req, " perm"}, rspPerm, mPm[best]);
    end else expMisses++;
  endtask

  task automatic lookup(string req, logic [15:0] a, logic [AW-1:0] ad, int tg, int tsz);
    lkSet(a, ad, tg, tsz);
    lkFinish(req);
  endtask

  localparam logic [AW-1:0] ADDR_A = 48'h1234_5678_9ABC;

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < N; i++) mV[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", rspValid, 0);
    chk("R1 hitCount", hitCount, 0);
    chk("R1 missCount", missCount, 0);
    rstN = 1;
    @(negedge clk);
    lookup("R1 empty lookup", 16'd5, ADDR_A, 1, 16);
    chk("R1 empty miss", rspHit, 0);

    // R2 basic hit, identifier mismatch, level priority and start level
    doInsert(16'd5, ADDR_A, 1, 3, 48'h0000_AAAA_B000, 2);
    lookup("R2 page hit", 16'd5, ADDR_A, 1, 16);
    chk("R2 page out", rspOutAddr, 48'h0000_AAAA_BABC);
    lookup("R2 other asid", 16'd6, ADDR_A, 1, 16);
    chk("R2 other asid miss", rspHit, 0);
    doInsert(16'd5, ADDR_A, 1, 2, 48'h0000_7700_0000, 1);
    doInsert(16'd5, ADDR_A, 1, 1, 48'h0000_8000_0000, 3);
    lookup("R2 lowest level", 16'd5, ADDR_A, 1, 16);
    chk("R2 lowest level is 1", rspLevel, 1);
    lookup("R2 start level 2", 16'd5, ADDR_A, 1, 34);
    chk("R2 start 2 gives level 2", rspLevel, 2);
    lookup("R2 start level 3", 16'd5, ADDR_A, 1, 48);
    chk("R2 start 3 gives level 3", rspLevel, 3);

    // R9 exact removal spares overlapping blocks
    doInval(2, 0, 16'd5, 48'h1234_5678_9000, 1, 1, 3);
    lookup("R9 exact gone", 16'd5, ADDR_A, 1, 48);
    chk("R9 exact entry removed", rspHit, 0);
    lookup("R9 block kept", 16'd5, ADDR_A, 1, 34);
    chk("R9 level 2 block kept", rspHit, 1);

    // R8 fallback scan when the hinted tag misses
    doInsert(16'd5, ADDR_A, 1, 3, 48'h0000_AAAA_B000, 2);
    doInval(2, 0, 16'd5, 48'h1234_5678_9000, 1, 1, 2);
    lookup("R8 scan removes all", 16'd5, ADDR_A, 1, 16);
    chk("R8 scan miss", rspHit, 0);

    // R8 entry inside request range, identifier filter, any identifier
    doInsert(16'd7, 48'h0000_0040_3000, 1, 3, 48'h0000_0001_0000, 1);
    doInsert(16'd7, 48'h0000_0041_0000, 1, 3, 48'h0000_0002_0000, 1);
    doInsert(16'd8, 48'h0000_0040_2000, 1, 3, 48'h0000_0003_0000, 1);
    doInval(2, 0, 16'd7, 48'h0000_0040_0000, 0, 16, 0);
    lookup("R8 inside range", 16'd7, 48'h0000_0040_3010, 1, 16);
    chk("R8 inside range removed", rspHit, 0);
    lookup("R8 outside range", 16'd7, 48'h0000_0041_0000, 1, 16);
    chk("R8 outside range kept", rspHit, 1);
    lookup("R8 other asid", 16'd8, 48'h0000_0040_2000, 1, 16);
    chk("R8 other asid kept", rspHit, 1);

    // R7 identifier flush
    doInsert(16'd8, 48'h0000_0090_0000, 1, 3, 48'h0000_0004_0000, 0);
    doInval(1, 0, 16'd7, 0, 0, 0, 0);
    lookup("R7 asid 7 gone", 16'd7, 48'h0000_0041_0000, 1, 16);
    chk("R7 asid 7 miss", rspHit, 0);
    lookup("R7 asid 8 kept", 16'd8, 48'h0000_0040_2000, 1, 16);
    chk("R7 asid 8 hit", rspHit, 1);

    // R6 full flush
    doInval(0, 0, 0, 0, 0, 0, 0);
    lookup("R6 after flush", 16'd8, 48'h0000_0040_2000, 1, 16);
    chk("R6 flush miss", rspHit, 0);

    // R3 larger granules and granule code in the tag
    doInsert(16'd3, 48'h0000_0002_3456, 2, 3, 48'h0000_0055_0000, 1);
    lookup("R3 16K top", 16'd3, 48'h0000_0002_3FFF, 2, 16);
    chk("R3 16K hit", rspHit, 1);
    lookup("R3 16K next", 16'd3, 48'h0000_0002_4000, 2, 16);
    chk("R3 16K next miss", rspHit, 0);
    doInsert(16'd3, 48'h0000_2345_6789, 3, 2, 48'h0000_4000_0000, 2);
    lookup("R3 64K block", 16'd3, 48'h0000_2000_0000, 3, 16);
    chk("R3 64K block hit", rspHit, 1);
    lookup("R3 granule code differs", 16'd3, 48'h0000_2000_0000, 1, 16);
    chk("R3 granule mismatch miss", rspHit, 0);

    // R4 overwrite and R5 full-cache flush
    doInval(0, 0, 0, 0, 0, 0, 0);
    doInsert(16'd9, 48'h0000_0000_0000, 1, 3, 48'h0000_0100_0000, 1);
    doInsert(16'd9, 48'h0000_0000_0000, 1, 3, 48'h0000_0200_0000, 2);
    lookup("R4 overwrite", 16'd9, 48'h0000_0000_0010, 1, 16);
    chk("R4 new output", rspOutAddr, 48'h0000_0200_0010);
    for (int i = 1; i < N; i++) doInsert(16'd9, AW'(i) << 12, 1, 3, AW'(i) << 24, 0);
    lookup("R4 single slot used", 16'd9, 48'h0000_0000_0010, 1, 16);
    chk("R4 first still held", rspHit, 1);
    doInsert(16'd9, 48'h0000_00F0_0000, 1, 3, 48'h0000_0300_0000, 3);
    lookup("R5 old flushed", 16'd9, 48'h0000_0000_1000, 1, 16);
    chk("R5 old entry miss", rspHit, 0);
    lookup("R5 new present", 16'd9, 48'h0000_00F0_0000, 1, 16);
    chk("R5 new entry hit", rspHit, 1);

    // R11 lookup beside invalidate, then beside insert
    lkSet(16'd9, 48'h0000_00F0_0000, 1, 16);
    invKind = 2'd0; invValid = 1;
    #1;
    chk("R11 lookup held by invalidate", lkReady, 0);
    chk("R11 invalidate ready", invReady, 1);
    @(posedge clk); @(negedge clk);
    invValid = 0;
    modelInval(0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R11 lookup released", lkReady, 1);
    lkFinish("R11 after flush");
    chk("R11 held lookup misses", rspHit, 0);
    lkSet(16'd4, 48'h0000_0077_7000, 1, 16);
    insAsid = 16'd4; insAddr = 48'h0000_0077_7000; insTg = 1; insLevel = 3;
    insOutAddr = 48'h0000_0066_6000; insPerm = 1; insValid = 1;
    #1;
    chk("R11 lookup held by insert", lkReady, 0);
    chk("R11 insert ready", insReady, 1);
    @(posedge clk); @(negedge clk);
    insValid = 0;
    modelInsert(16'd4, 48'h0000_0077_7000, 1, 3, 48'h0000_0066_6000, 1);
    lkFinish("R11 after insert");
    chk("R11 held lookup hits", rspHit, 1);

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] a = 16'($urandom_range(1, 3));
      logic [AW-1:0] ad = 48'h0000_8000_0000 | AW'($urandom & 32'h07FF_FFFF);
      int tg = $urandom_range(1, 2);
      if (op < 4) doInsert(a, ad, tg, $urandom_range(1, 3), AW'($urandom) << 16, $urandom_range(0, 3));
      else if (op < 8) lookup("R2 random lookup", a, ad, tg, 16);
      else if (op == 8) doInval(2, $urandom_range(0, 1), a, ad & ~48'hFFF, $urandom_range(0, 2),
                                $urandom_range(1, 4), $urandom_range(0, 3));
      else doInval(1, 0, a, 0, 0, 0, 0);
    end

    // R10 counters
    chk("R10 hitCount", hitCount, CW'(expHits));
    chk("R10 missCount", missCount, CW'(expMisses));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule